// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a processor core and the interrupt sources of a microcontroller-class chip. It gathers sixteen priority levels of requests and decides which level is currently pending. It then raises a single request toward the core, carrying the 16-bit address of the vector word that the core should fetch. The vector word for level L lives at `VEC_BASE + 2*L`. Level 15 is the highest priority and level 0 the lowest.

Each level belongs to one of three masking tiers.
- **Level 15 (reset):** cannot be masked at all.
- **Level 14 (nonmaskable tier):** collects three flags held inside the block (external NMI pin event, clock fault, memory access violation). Each flag has its own enable bit. This tier ignores the core's global interrupt enable.
- **Levels 13 down to 0 (maskable):** each takes a request line from a peripheral. A request needs both its per-level enable bit and the global enable.

The watchdog level is an exception within the maskable range. Its enable only counts while the watchdog runs as an interval timer.

A small byte-wide register port exposes the enables and the nonmaskable flags. Once presented, a vector stays frozen until the core acknowledges it; only a reset request can displace it. On acknowledge, the block pulses a clear strobe back to the owning peripheral, but only for levels with a single source. Shared levels leave flag clearing to software.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After power-up clear, `irq_o` is 0 and all enable bits read 0. The flag register (address 1) reads 8'h02, because the clock-fault flag comes up set.
- R2: The presented vector equals 16'hFFE0 plus twice the level being served (level 15 gives 16'hFFFE, level 0 gives 16'hFFE0).
- R3: When several levels are pending at the moment a new vector is taken, the highest-numbered level is chosen.
- R4: A reset request (`rst_req_i` high) is presented as level 15 one clock later, even when another vector is being held unacknowledged. No enable can block it.
- R5: Level 14 is pending when any flag is set together with its own enable bit (address 0, bit 0 = NMI pin, bit 1 = clock fault, bit 2 = access violation). The level is blocked when that enable is 0 and ignores `gie_i`.
- R6: A maskable level n (0 to 13) is pending only when `req_i[n]`, its enable bit and `gie_i` are all 1.
- R7: The watchdog level (10) is pending only while `wdt_interval_i` is 1, in addition to the conditions in R6.
- R8: While `irq_o` is 1 and neither `ack_i` nor a reset request arrives, `irq_o` and `vec_o` hold their values. This includes the case where a higher maskable request appears.
- R9: When `ack_i` is high while `irq_o` is 1, `irq_o` drops on that clock edge. For a single-source level, `clr_o` carries a one-cycle one-hot pulse on that level's bit. For shared levels (1, 4, 5, 12, 14), `clr_o` stays 0.
- R10: The register map is as follows; unallocated bits read 0 and ignore writes.
  - Address 0, bits [2:0]: the level-14 enables.
  - Address 1, bits [2:0]: the level-14 flags, in the same bit order as the enables.
  - Address 2: the enables for levels 7..0, where bit n enables level n.
  - Address 3, bits [5:0]: the enables for levels 13..8.
- R11: A pulse on `evt_i[k]` sets flag k. It also wins over a software write of 0 to that flag in the same cycle.
- R12: Level 14 is a shared level. It stays pending while any of its enabled flags remains set, and acknowledging it does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up clear |
| rst_req_i | input | 1 | Reset request; served as level 15 |
| gie_i | input | 1 | Global interrupt enable from the core |
| wdt_interval_i | input | 1 | Watchdog runs in interval-timer mode |
| req_i | input | 14 | Request lines for maskable levels 13..0 |
| evt_i | input | 3 | Set pulses for level-14 flags (0 NMI pin, 1 clock fault, 2 access violation) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| ack_i | input | 1 | Core accepts the presented vector |
| irq_o | output | 1 | Vector request to the core |
| vec_o | output | 16 | Address of the vector word |
| clr_o | output | 16 | One-cycle clear strobe, one bit per level |

## Verification
The bench targets the following corner cases.
- **Higher request while a vector is held.** A controller that re-arbitrated every cycle would change `vec_o` under the core's fetch.
- **Reset request during an unacknowledged maskable service.** A design that waited for the acknowledge would leave the core on the wrong handler.
- **Masking tiers.** A nonmaskable request is raised with the global enable low. A watchdog request is raised with interval mode off. A wrong tier shows as a spurious or missing `irq_o`.
- **Shared and single-source acknowledge.** A wrong shared mask pulses `clr_o` on a shared level or misses the owner of a single one.
- **Event versus software clear in the same cycle.** A design that let the write win would lose an event.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   typedef enum logic [1:0] {
      TIER_RESET = 2'd0,
      TIER_NMI   = 2'd1,
      TIER_MASK  = 2'd2
   } tier_e;

   // Vector word address of a level: base plus two bytes per level.
   function automatic logic [15:0] vec_addr(input logic [15:0] base, input int unsigned lvl);
      return base + 16'(lvl * 2);
   endfunction

   // Tier of a level: top is reset, next is nonmaskable, the rest maskable.
   function automatic tier_e tier_of(input int lvl, input int nlvl);
      if (lvl == nlvl - 1)      return TIER_RESET;
      else if (lvl == nlvl - 2) return TIER_NMI;
      else                      return TIER_MASK;
   endfunction

endpackage

// File: rtl/ivc_regs.sv
module ivc_regs #(
   parameter int          NMI_SRC   = 3,
   parameter int          MASK_LVLS = 14,
   parameter logic [7:0]  FLAG_RST  = 8'h02
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [1:0]           addr_i,
   input  logic [7:0]           wdata_i,
   input  logic [NMI_SRC-1:0]   evt_i,
   output logic [7:0]           rdata_o,
   output logic [NMI_SRC-1:0]   nmi_en_o,
   output logic [NMI_SRC-1:0]   nmi_flag_o,
   output logic [MASK_LVLS-1:0] lvl_en_o
);
   localparam logic [1:0] A_NMI_EN = 2'd0;
   localparam logic [1:0] A_FLAG   = 2'd1;
   localparam logic [1:0] A_EN_LO  = 2'd2;
   localparam logic [1:0] A_EN_HI  = 2'd3;
   localparam logic [NMI_SRC-1:0] FLAG_INIT = FLAG_RST[NMI_SRC-1:0];

   logic [NMI_SRC-1:0]   nmi_en_q, flag_q;
   logic [MASK_LVLS-1:0] lvl_en_q;
   logic [15:0]          en_pad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_en_q <= '0;
         flag_q   <= FLAG_INIT;
      end else begin
         if (we_i && addr_i == A_NMI_EN) nmi_en_q <= wdata_i[NMI_SRC-1:0];
         if (we_i && addr_i == A_FLAG) flag_q <= wdata_i[NMI_SRC-1:0] | evt_i;
         else                          flag_q <= flag_q | evt_i;
      end
   end

   generate
      for (genvar b = 0; b < MASK_LVLS; b++) begin : g_en
         localparam logic [1:0] BYTE_A = (b < 8) ? A_EN_LO : A_EN_HI;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       lvl_en_q[b] <= 1'b0;
            else if (we_i && addr_i == BYTE_A) lvl_en_q[b] <= wdata_i[b % 8];
         end
      end
   endgenerate

   assign en_pad = 16'(lvl_en_q);

   always_comb begin
      unique case (addr_i)
         A_NMI_EN: rdata_o = 8'(nmi_en_q);
         A_FLAG:   rdata_o = 8'(flag_q);
         A_EN_LO:  rdata_o = en_pad[7:0];
         default:  rdata_o = en_pad[15:8];
      endcase
   end

   assign nmi_en_o   = nmi_en_q;
   assign nmi_flag_o = flag_q;
   assign lvl_en_o   = lvl_en_q;

   AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R11

endmodule

// File: rtl/ivc_pending.sv
module ivc_pending #(
   parameter int NUM_LVL   = 16,
   parameter int NMI_SRC   = 3,
   parameter int WDT_LVL   = 10
) (
   input  logic                   rst_req_i,
   input  logic                   gie_i,
   input  logic                   wdt_interval_i,
   input  logic [NUM_LVL-3:0]     req_i,
   input  logic [NUM_LVL-3:0]     lvl_en_i,
   input  logic [NMI_SRC-1:0]     nmi_flag_i,
   input  logic [NMI_SRC-1:0]     nmi_en_i,
   output logic [NUM_LVL-1:0]     pend_o
);
   import ivc_pkg::*;

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         localparam tier_e T = tier_of(l, NUM_LVL);
         if (T == TIER_RESET) begin : g_rst
            assign pend_o[l] = rst_req_i;
         end else if (T == TIER_NMI) begin : g_nmi
            assign pend_o[l] = |(nmi_flag_i & nmi_en_i);
         end else if (l == WDT_LVL) begin : g_wdt
            assign pend_o[l] = req_i[l] & lvl_en_i[l] & gie_i & wdt_interval_i;
         end else begin : g_msk
            assign pend_o[l] = req_i[l] & lvl_en_i[l] & gie_i;
         end
      end
   endgenerate

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
   parameter int NUM_LVL = 16,
   localparam int LW     = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] pend_i,
   output logic               win_any_o,
   output logic [LW-1:0]      win_lvl_o
);
   always_comb begin
      win_any_o = 1'b0;
      win_lvl_o = '0;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (pend_i[l]) begin
            win_any_o = 1'b1;
            win_lvl_o = LW'(l);
         end
      end
   end

   AST_NO_HIGHER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      win_any_o |-> ((pend_i >> win_lvl_o) == NUM_LVL'(1))); // R3

endmodule

// File: rtl/ivc_vecreg.sv
module ivc_vecreg #(
   parameter int          NUM_LVL     = 16,
   parameter logic [15:0] VEC_BASE    = 16'hFFE0,
   parameter logic [15:0] SHARED_MASK = 16'h5032,
   localparam int         LW          = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req_i,
   input  logic               ack_i,
   input  logic               win_any_i,
   input  logic [LW-1:0]      win_lvl_i,
   output logic               irq_o,
   output logic [15:0]        vec_o,
   output logic [NUM_LVL-1:0] clr_o
);
   import ivc_pkg::*;

   localparam logic [LW-1:0]      RST_LVL = LW'(NUM_LVL - 1);
   localparam logic [NUM_LVL-1:0] SHM     = SHARED_MASK[NUM_LVL-1:0];

   logic               irq_q;
   logic [LW-1:0]      lvl_q;
   logic [15:0]        vec_q;
   logic [NUM_LVL-1:0] clr_q;
   logic               preempt;

   assign preempt = rst_req_i && !(irq_q && lvl_q == RST_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         lvl_q <= '0;
         vec_q <= VEC_BASE;
         clr_q <= '0;
      end else begin
         clr_q <= '0;
         if (preempt) begin
            irq_q <= 1'b1;
            lvl_q <= RST_LVL;
            vec_q <= vec_addr(VEC_BASE, 32'(RST_LVL));
         end else if (irq_q && ack_i) begin
            irq_q <= 1'b0;
            if (!SHM[lvl_q]) clr_q <= NUM_LVL'(1) << lvl_q;
         end else if (!irq_q && win_any_i) begin
            irq_q <= 1'b1;
            lvl_q <= win_lvl_i;
            vec_q <= vec_addr(VEC_BASE, 32'(win_lvl_i));
         end
      end
   end

   assign irq_o = irq_q;
   assign vec_o = vec_q;
   assign clr_o = clr_q;

   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i && !rst_req_i) |=> (irq_o && $stable(vec_o))); // R8
   AST_RESET_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_i && !(irq_o && vec_o == vec_addr(VEC_BASE, NUM_LVL - 1)))
      |=> (irq_o && vec_o == vec_addr(VEC_BASE, NUM_LVL - 1))); // R4
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o)); // R9
   AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> ($past(ack_i) && $past(irq_o) && !irq_o)); // R9

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int          NUM_LVL     = 16,
   parameter int          NMI_SRC     = 3,
   parameter int          WDT_LVL     = 10,
   parameter logic [15:0] VEC_BASE    = 16'hFFE0,
   parameter logic [15:0] SHARED_MASK = 16'h5032,
   parameter logic [7:0]  FLAG_RST    = 8'h02,
   localparam int         MASK_LVLS   = NUM_LVL - 2,
   localparam int         LW          = $clog2(NUM_LVL)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rst_req_i,
   input  logic                 gie_i,
   input  logic                 wdt_interval_i,
   input  logic [MASK_LVLS-1:0] req_i,
   input  logic [NMI_SRC-1:0]   evt_i,
   input  logic                 reg_we_i,
   input  logic [1:0]           reg_addr_i,
   input  logic [7:0]           reg_wdata_i,
   output logic [7:0]           reg_rdata_o,
   input  logic                 ack_i,
   output logic                 irq_o,
   output logic [15:0]          vec_o,
   output logic [NUM_LVL-1:0]   clr_o
);
   import ivc_pkg::*;

   // Elaboration-time parameter checks
   if (NUM_LVL < 4 || NUM_LVL > 16) begin : g_bad_lvl
      $error("NUM_LVL must lie in 4..16");
   end
   if (NMI_SRC < 1 || NMI_SRC > 8) begin : g_bad_src
      $error("NMI_SRC must lie in 1..8");
   end
   if (WDT_LVL < 0 || WDT_LVL >= MASK_LVLS) begin : g_bad_wdt
      $error("WDT_LVL must be a maskable level");
   end
   if (VEC_BASE[0] != 1'b0) begin : g_bad_base
      $error("VEC_BASE must be word aligned");
   end

   logic [NMI_SRC-1:0]   nmi_en, nmi_flag;
   logic [MASK_LVLS-1:0] lvl_en;
   logic [NUM_LVL-1:0]   pend;
   logic                 win_any;
   logic [LW-1:0]        win_lvl;

   ivc_regs #(.NMI_SRC(NMI_SRC), .MASK_LVLS(MASK_LVLS), .FLAG_RST(FLAG_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .evt_i(evt_i), .rdata_o(reg_rdata_o),
      .nmi_en_o(nmi_en), .nmi_flag_o(nmi_flag), .lvl_en_o(lvl_en));

   ivc_pending #(.NUM_LVL(NUM_LVL), .NMI_SRC(NMI_SRC), .WDT_LVL(WDT_LVL)) u_pend (
      .rst_req_i(rst_req_i), .gie_i(gie_i), .wdt_interval_i(wdt_interval_i),
      .req_i(req_i), .lvl_en_i(lvl_en), .nmi_flag_i(nmi_flag), .nmi_en_i(nmi_en),
      .pend_o(pend));

   ivc_arbiter #(.NUM_LVL(NUM_LVL)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend),
      .win_any_o(win_any), .win_lvl_o(win_lvl));

   ivc_vecreg #(.NUM_LVL(NUM_LVL), .VEC_BASE(VEC_BASE), .SHARED_MASK(SHARED_MASK)) u_vec (
      .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .ack_i(ack_i),
      .win_any_i(win_any), .win_lvl_i(win_lvl),
      .irq_o(irq_o), .vec_o(vec_o), .clr_o(clr_o));

   AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_o) && vec_o < vec_addr(VEC_BASE, NUM_LVL - 2)) |-> $past(gie_i)); // R6
   AST_NMI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_o) && vec_o == vec_addr(VEC_BASE, NUM_LVL - 2))
      |-> ($past(nmi_en & nmi_flag) != '0)); // R5

endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/100ps
module tb_irq_vector_ctrl;

   localparam logic [15:0] SHM = 16'h5032;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0, gie = 1'b0, wdt = 1'b0, ack = 1'b0;
   logic [13:0] req = '0;
   logic [2:0]  evt = '0;
   logic        we = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq_o;
   logic [15:0] vec_o, clr_o;

   always #2.5 clk = ~clk;

   irq_vector_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .gie_i(gie),
      .wdt_interval_i(wdt), .req_i(req), .evt_i(evt), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .ack_i(ack), .irq_o(irq_o), .vec_o(vec_o), .clr_o(clr_o));

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [2:0]  m_nen, m_flg;
   logic [13:0] m_len;
   logic        m_irq;
   int          m_lvl;
   logic [15:0] m_clr;

   function automatic bit m_pend(input int l);
      if (l == 15) return rst_req;
      if (l == 14) return |(m_flg & m_nen);
      if (l == 10) return req[l] && m_len[l] && gie && wdt;
      return req[l] && m_len[l] && gie;
   endfunction

   function automatic logic [7:0] m_rd(input logic [1:0] a);
      logic [15:0] p;
      p = {2'b00, m_len};
      case (a)
         2'd0:    return {5'd0, m_nen};
         2'd1:    return {5'd0, m_flg};
         2'd2:    return p[7:0];
         default: return p[15:8];
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_nen = '0; m_flg = 3'b010; m_len = '0;
         m_irq = 1'b0; m_lvl = 0; m_clr = '0;
      end else begin
         int w;
         w = -1;
         for (int l = 0; l < 16; l++) if (m_pend(l)) w = l;
         m_clr = '0;
         if (rst_req && !(m_irq && m_lvl == 15)) begin
            m_irq = 1'b1; m_lvl = 15;
         end else if (m_irq && ack) begin
            m_irq = 1'b0;
            if (!SHM[m_lvl]) m_clr = 16'd1 << m_lvl;
         end else if (!m_irq && w >= 0) begin
            m_irq = 1'b1; m_lvl = w;
         end
         if (we && addr == 2'd0) m_nen = wdata[2:0];
         if (we && addr == 2'd1) m_flg = wdata[2:0] | evt;
         else                    m_flg = m_flg | evt;
         if (we && addr == 2'd2) m_len[7:0] = wdata;
         if (we && addr == 2'd3) m_len[13:8] = wdata[5:0];
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R8 irq_o vs model", irq_o, m_irq);
         if (m_irq) chk("R2 vec_o vs model", vec_o, 16'hFFE0 + 16'(2 * m_lvl));
         chk("R9 clr_o vs model", clr_o, m_clr);
         chk("R10 rdata vs model", rdata, m_rd(addr));
      end
   end

   // ---------------- watchdog ----------------
   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete actual=%0d expected<=20000", cyc);
         summary();
         $finish;
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      tick(1);
      we = 1'b0;
   endtask

   task automatic rdchk(input string rq, input logic [1:0] a, input logic [7:0] exp);
      addr = a;
      #0.5;
      chk(rq, rdata, exp);
   endtask

   task automatic ack_one(input int drop_lvl);
      ack = 1'b1;
      if (drop_lvl >= 0 && drop_lvl < 14) req[drop_lvl] = 1'b0;
      tick(1);
      ack = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 irq_o after reset", irq_o, 0);
      rdchk("R1 flag reset value", 2'd1, 8'h02);
      rdchk("R1 nmi enables reset", 2'd0, 8'h00);
      rdchk("R1 level enables reset", 2'd2, 8'h00);

      // R10 unallocated bits
      wr(2'd0, 8'hF8); rdchk("R10 addr0 unallocated", 2'd0, 8'h00);
      wr(2'd3, 8'hC0); rdchk("R10 addr3 unallocated", 2'd3, 8'h00);
      wr(2'd3, 8'hFF); rdchk("R10 addr3 allocated", 2'd3, 8'h3F);
      wr(2'd3, 8'h00);

      // R6 maskable needs global enable
      wr(2'd2, 8'h08); req[3] = 1'b1;
      tick(3); chk("R6 blocked by gie", irq_o, 0);
      gie = 1'b1; tick(1);
      chk("R6 served with gie", irq_o, 1);
      chk("R2 vector level 3", vec_o, 16'hFFE6);

      // R8 hold while higher request arrives
      wr(2'd2, 8'h88); req[7] = 1'b1;
      tick(2); chk("R8 vector held", vec_o, 16'hFFE6);

      // R9 single-source clear
      ack_one(3);
      chk("R9 clear strobe level 3", clr_o, 16'h0008);
      chk("R9 irq drops on ack", irq_o, 0);
      tick(1);
      chk("R3 next winner level 7", vec_o, 16'hFFEE);

      // R3 ordering of several pending
      wr(2'd2, 8'h84); wr(2'd3, 8'h02);
      req[2] = 1'b1; req[9] = 1'b1;
      ack_one(7);
      chk("R9 clear strobe level 7", clr_o, 16'h0080);
      tick(1); chk("R3 level 9 over 2", vec_o, 16'hFFF2);
      ack_one(9); tick(1);
      chk("R3 then level 2", vec_o, 16'hFFE4);
      ack_one(2); tick(2);
      chk("R3 idle when none pending", irq_o, 0);

      // R9 shared level gives no strobe
      wr(2'd3, 8'h10); req[12] = 1'b1; tick(1);
      chk("R2 vector level 12", vec_o, 16'hFFF8);
      ack_one(12);
      chk("R9 shared level no strobe", clr_o, 16'h0000);

      // R7 watchdog level needs interval mode
      wr(2'd3, 8'h04); req[10] = 1'b1;
      tick(3); chk("R7 blocked in watchdog mode", irq_o, 0);
      wdt = 1'b1; tick(1);
      chk("R7 served in interval mode", vec_o, 16'hFFF4);
      ack_one(10); wdt = 1'b0;
      wr(2'd3, 8'h00);

      // R5 / R12 nonmaskable tier
      gie = 1'b0;
      wr(2'd0, 8'h02); tick(1);
      chk("R5 clock fault without gie", irq_o, 1);
      chk("R5 vector level 14", vec_o, 16'hFFFC);
      we = 1'b1; addr = 2'd1; wdata = 8'h00; ack = 1'b1;
      tick(1);
      we = 1'b0; ack = 1'b0;
      chk("R12 shared level 14 no strobe", clr_o, 16'h0000);
      tick(2); chk("R12 quiet after flag clear", irq_o, 0);
      evt[0] = 1'b1; tick(1); evt[0] = 1'b0;
      tick(2); chk("R5 blocked by own enable", irq_o, 0);
      rdchk("R11 pin flag set", 2'd1, 8'h01);
      wr(2'd0, 8'h01); tick(1);
      chk("R12 pending from pin flag", vec_o, 16'hFFFC);
      ack = 1'b1; tick(1); ack = 1'b0;
      tick(1); chk("R12 re-pends while flag set", irq_o, 1);
      we = 1'b1; addr = 2'd1; wdata = 8'h00; ack = 1'b1;
      tick(1);
      we = 1'b0; ack = 1'b0;
      wr(2'd0, 8'h00); tick(1);

      // R11 event beats software clear
      we = 1'b1; addr = 2'd1; wdata = 8'h00; evt[2] = 1'b1;
      tick(1);
      we = 1'b0; evt[2] = 1'b0;
      rdchk("R11 event wins over write", 2'd1, 8'h04);
      wr(2'd1, 8'h00);

      // R4 reset request preempts a held service
      gie = 1'b1; wr(2'd2, 8'h08); req[3] = 1'b1; tick(1);
      chk("R4 maskable held first", vec_o, 16'hFFE6);
      rst_req = 1'b1; tick(1); rst_req = 1'b0;
      chk("R4 reset vector presented", vec_o, 16'hFFFE);
      chk("R4 irq during reset", irq_o, 1);
      ack_one(3);
      chk("R4 reset strobe", clr_o, 16'h8000);
      tick(2); chk("R4 idle afterwards", irq_o, 0);

      tick(2);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule